// File: doc/BRIEF.md
# Debug Control Register Responder

This block is the target side of a simple request/acknowledge debug bus. It stands in for a processor core's debug port when a debug front end is tested without a real core. The requester raises a request together with a write-enable, an address and write data. The responder answers each accepted request with a single-cycle acknowledge pulse. In the acknowledge cycle it also presents read data.

Two addresses do something. The control address holds a small status register: bit 0 means stopping, bit 1 means stopped and bit 2 means terminated. Writes to this address are interpreted as commands and are not stored as written. The machine-state address returns a fixed test word when read. Every other access is acknowledged and changes nothing. A requester must drop its request once it has seen the acknowledge.

Top module: `dbg_ctl_responder`

## Requirements
- R1: After reset, acknowledge and read data are low, and the status register holds 3'b100 (terminated), as a read of the control address (0) shows.
- R2: While request is low no acknowledge is produced; acknowledge stays low in the cycle after any cycle where request was low.
- R3: A request seen while acknowledge is low is answered by acknowledge high in the next cycle, and acknowledge is low again in the cycle after that.
- R4: A read (write-enable low) of the control address returns the current status register, zero-extended, on read data during the acknowledge cycle.
- R5: A write to the control address with command bit 0 (stop) set sets status bit 1 (stopped), clears status bit 0 (stopping) and keeps bit 2.
- R6: A write to the control address with command bit 1 (start) set clears the whole status register to zero, even when bit 0 is also set.
- R7: A read of the machine-state address (1) returns 64'h00000000DEADBEEF in the acknowledge cycle.
- R8: Reads or writes to any other address, and writes to address 1, are acknowledged, leave the status register unchanged and return zero read data.
- R9: Read data is zero whenever acknowledge is low, and during the acknowledge of any write.
- R10: A request held high through its acknowledge is taken as a new request in the cycle after the acknowledge, so a held request yields acknowledge 1, 0, 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register address |
| wdata_i | input | 64 | Write data / command bits |
| ack_o | output | 1 | One-cycle acknowledge |
| rdata_o | output | 64 | Read data, valid with acknowledge |

## Verification
The hardest case to reach is a stop command arriving after the register has already been cleared by start. Only then does the stopped bit become set while terminated stays low, which shows that the stop handling keeps unrelated bits. The vector table reaches this state by issuing start, then stop, then a readback. A second hard case is a request held through its acknowledge. A directed test keeps the request high for three cycles and checks the 1, 0, 1 acknowledge pattern. The same test checks that read data is zero in the gap cycle.

// File: rtl/dbg_rsp_pkg.sv
package dbg_rsp_pkg;
  localparam int STAT_W        = 3;
  localparam int CMD_STOP_BIT  = 0;
  localparam int CMD_START_BIT = 1;
  localparam int ST_STOPPING   = 0;
  localparam int ST_STOPPED    = 1;
  localparam int ST_TERMINATED = 2;
  localparam logic [STAT_W-1:0] STAT_RESET = 3'b100;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_CTRL_RD,
    ACC_CTRL_WR,
    ACC_STATE_RD,
    ACC_OTHER
  } acc_kind_e;
endpackage

// File: rtl/dbg_rsp_handshake.sv
module dbg_rsp_handshake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic accept_o,
  output logic ack_o
);
  logic ack_q;

  // a request overlapping its own ack is not re-accepted until the next cycle
  assign accept_o = req_i && !ack_q;
  assign ack_o    = ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= accept_o;
  end
endmodule

// File: rtl/dbg_rsp_ctrl_reg.sv
module dbg_rsp_ctrl_reg
  import dbg_rsp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] cmd_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (wr_en_i) begin
      if (cmd_i[CMD_STOP_BIT]) begin
        stat_d[ST_STOPPED]  = 1'b1;
        stat_d[ST_STOPPING] = 1'b0;
      end
      // start is applied last and therefore overrides stop
      if (cmd_i[CMD_START_BIT]) stat_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= STAT_RESET;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/dbg_rsp_rdata.sv
module dbg_rsp_rdata
  import dbg_rsp_pkg::*;
#(
  parameter int                DATA_W     = 64,
  parameter logic [DATA_W-1:0] STATE_WORD = 64'hDEADBEEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  acc_kind_e         kind_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = '0;
    if (accept_i) begin
      unique case (kind_i)
        ACC_CTRL_RD:  rdata_d = {{PAD_W{1'b0}}, stat_i};
        ACC_STATE_RD: rdata_d = STATE_WORD;
        default:      rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dbg_ctl_responder.sv
module dbg_ctl_responder
  import dbg_rsp_pkg::*;
#(
  parameter int                DATA_W     = 64,
  parameter int                ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 4'd0,
  parameter logic [ADDR_W-1:0] STATE_ADDR = 4'd1,
  parameter logic [DATA_W-1:0] STATE_WORD = 64'hDEADBEEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              accept;
  logic [STAT_W-1:0] stat;
  acc_kind_e         kind;

  always_comb begin
    kind = ACC_NONE;
    if (accept) begin
      if (addr_i == CTRL_ADDR)                kind = we_i ? ACC_CTRL_WR : ACC_CTRL_RD;
      else if (addr_i == STATE_ADDR && !we_i) kind = ACC_STATE_RD;
      else                                    kind = ACC_OTHER;
    end
  end

  dbg_rsp_handshake u_hs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .accept_o (accept),
    .ack_o    (ack_o)
  );

  dbg_rsp_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (kind == ACC_CTRL_WR),
    .cmd_i   (wdata_i),
    .stat_o  (stat)
  );

  dbg_rsp_rdata #(.DATA_W(DATA_W), .STATE_WORD(STATE_WORD)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .kind_i   (kind),
    .stat_i   (stat),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/dbg_rsp_checker.sv
module dbg_rsp_checker #(
  parameter int                DATA_W     = 64,
  parameter int                ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] STATE_ADDR = 4'd1,
  parameter logic [DATA_W-1:0] STATE_WORD = 64'hDEADBEEF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ack_o,
  input logic [DATA_W-1:0] rdata_o
);
  assert_no_req_no_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o);

  assert_ack_follows_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ack_o) |=> ack_o);

  assert_ack_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  assert_state_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ack_o && !we_i && addr_i == STATE_ADDR) |=> (rdata_o == STATE_WORD));

  assert_rdata_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> (rdata_o == '0));

  assert_write_rdata_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ack_o && we_i) |=> (rdata_o == '0));
endmodule

bind dbg_ctl_responder dbg_rsp_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STATE_ADDR(STATE_ADDR), .STATE_WORD(STATE_WORD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .ack_o(ack_o), .rdata_o(rdata_o)
);

// File: tb/tb_dbg_ctl_responder.sv
module tb_dbg_ctl_responder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic        ack;
  logic [63:0] rdata;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  dbg_ctl_responder dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata)
  );

  // {we, addr, wdata, expected rdata}
  localparam int NV = 15;
  localparam logic [132:0] VEC [NV] = '{
    {1'b0, 4'd0, 64'h0,    64'h4},         // R1 R4 reset value
    {1'b1, 4'd1, 64'h3,    64'h0},         // R8 write to state addr
    {1'b0, 4'd0, 64'h0,    64'h4},         // R8 unchanged
    {1'b1, 4'd0, 64'h1,    64'h0},         // R5 stop
    {1'b0, 4'd0, 64'h0,    64'h6},         // R5 stopped + terminated
    {1'b0, 4'd1, 64'h0,    64'hDEADBEEF},  // R7
    {1'b1, 4'd0, 64'h3,    64'h0},         // R6 start + stop
    {1'b0, 4'd0, 64'h0,    64'h0},         // R6 cleared
    {1'b1, 4'd0, 64'h1,    64'h0},         // R5 stop from zero
    {1'b0, 4'd0, 64'h0,    64'h2},         // R5 bit 2 kept low
    {1'b1, 4'd7, 64'hFFFF, 64'h0},         // R8 other write
    {1'b0, 4'd7, 64'h0,    64'h0},         // R8 other read
    {1'b0, 4'd0, 64'h0,    64'h2},         // R8 unchanged
    {1'b1, 4'd0, 64'h2,    64'h0},         // R6 start
    {1'b0, 4'd0, 64'h0,    64'h0}          // R6 cleared
  };
  localparam int VREQ [NV] = '{4, 8, 8, 5, 5, 7, 6, 6, 5, 5, 8, 8, 8, 6, 6};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [3:0] a, input logic [63:0] d,
                        output logic [63:0] rd, output logic ack_hi, output logic ack_after);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    ack_hi = ack; rd = rdata;
    req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    @(negedge clk);
    ack_after = ack;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=5000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    logic ah, aa;
    repeat (3) @(negedge clk);
    check("R1 ack in reset", {63'b0, ack}, 64'h0);
    check("R1 rdata in reset", rdata, 64'h0);
    rst_ni = 1'b1;

    // R2: idle request, no ack
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2 idle ack", {63'b0, ack}, 64'h0);
    end

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][132], VEC[i][131:128], VEC[i][127:64], rd, ah, aa);
      check($sformatf("R3 ack high vec %0d", i), {63'b0, ah}, 64'h1);
      check($sformatf("R3 ack low after vec %0d", i), {63'b0, aa}, 64'h0);
      check($sformatf("R%0d rdata vec %0d", VREQ[i], i), rd, VEC[i][63:0]);
    end

    // R10: held request re-accepted; R9 rdata zero in gap
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 4'd1;
    @(negedge clk);
    check("R10 first ack", {63'b0, ack}, 64'h1);
    check("R7 held read data", rdata, 64'hDEADBEEF);
    @(negedge clk);
    check("R10 gap ack", {63'b0, ack}, 64'h0);
    check("R9 gap rdata", rdata, 64'h0);
    @(negedge clk);
    check("R10 second ack", {63'b0, ack}, 64'h1);
    req = 1'b0; addr = '0;
    @(negedge clk);
    check("R3 ack drops", {63'b0, ack}, 64'h0);

    // R9: write acknowledge carries zero data
    access(1'b1, 4'd0, 64'h1, rd, ah, aa);
    check("R9 write ack rdata", rd, 64'h0);

    // R1: reset in mid-life restores terminated
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    access(1'b0, 4'd0, 64'h0, rd, ah, aa);
    check("R1 reset restores status", rd, 64'h4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule